// File: doc/BRIEF.md
# Iterative Partial Remainder Unit

This block computes a truncating floating-point remainder over unpacked operands. The dividend arrives as a sign, a signed unbiased exponent and a normalized integer significand. The divisor arrives as an exponent and a significand only, because its sign has no effect on the result. The unit forms the integer quotient truncated toward zero, one quotient bit per clock, with a restoring shift-subtract loop. It returns the remainder in the same unpacked form, along with a four-bit condition word that encodes the low quotient bits.

The work of one call is bounded by the exponent gap, which is the dividend exponent minus the divisor exponent. When the gap is large, the call reduces the dividend only part of the way. It flags the result as incomplete, and software feeds the remainder back in until that flag clears. A one-cycle `start_i` launches an operation. `busy_o` stays high while it runs, and `done_o` pulses for one cycle when the outputs are valid. The outputs then hold until the next completion.

Top module: `prem_unit`

## Requirements
- R1: With gap g = dvd_exp − dvs_exp in 0..63 (0 ≤ g < GAP_LIMIT), let q = trunc(dvd_sig·2^g / dvs_sig). The remainder is dvd_sig·2^g − q·dvs_sig, scaled by the divisor exponent, so it is always smaller than the divisor.
- R2: With g ≥ 64, the divisor is scaled up by 2^(g−42). The quotient is trunc(dvd_sig·2^42 / dvs_sig), the remainder is taken at exponent scale dvd_exp − 42, `incomplete_o` is 1 and cc_o[2] is 1.
- R3: The condition word is cc_o = {C3,C2,C1,C0}. After a complete reduction, C2=0, C1=q bit 0, C0=q bit 2 and C3 = cc_i[3] OR q bit 1.
- R4: After a partial reduction, C0, C1 and C3 are copied from cc_i.
- R5: The remainder sign always equals the dividend sign. A zero remainder is returned as significand 0 and exponent 0 with the dividend's sign.
- R6: A nonzero remainder is renormalized: its significand MSB is set and its exponent is lowered by the leading-zero count.
- R7: With g < 0, the dividend is returned unchanged, q is 0 and incomplete_o is 0.
- R8: done_o is a one-cycle pulse. It rises g+2 clock edges after the edge that accepts start for g ≥ 0, with g capped at 42 for a partial reduction, and 1 edge after it for the pass-through cases of R7 and R10.
- R9: A start_i that arrives while busy_o is high is ignored, and the running result is unaffected.
- R10: A zero divisor significand returns the dividend unchanged with div_zero_o=1 and cc_o=cc_i. div_zero_o is 0 for any nonzero divisor.
- R11: busy_o is high from the edge that accepts start up to the edge that raises done_o, and busy_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, sampled when idle |
| dvd_sign_i | input | 1 | Dividend sign |
| dvd_exp_i | input | EXP_W | Dividend unbiased exponent, signed |
| dvd_sig_i | input | MW | Dividend normalized significand |
| dvs_exp_i | input | EXP_W | Divisor unbiased exponent, signed |
| dvs_sig_i | input | MW | Divisor normalized significand |
| cc_i | input | 4 | Prior condition word {C3,C2,C1,C0} |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| rem_sign_o | output | 1 | Remainder sign |
| rem_exp_o | output | EXP_W | Remainder exponent, signed |
| rem_sig_o | output | MW | Remainder significand |
| cc_o | output | 4 | New condition word {C3,C2,C1,C0} |
| incomplete_o | output | 1 | Partial reduction; call again |
| div_zero_o | output | 1 | Divisor was zero |

## Verification
The embedded assertions check these properties on every cycle:
- done_o lasts one cycle and never coincides with busy_o.
- The latched operands stay frozen while a run is in progress.
- The loop leaves a remainder below the divisor.
- Incomplete results carry C2, and error results are never marked incomplete.
- Nonzero results come out normalized, and the result sign follows the dividend.

Only the bench scenarios can show the rest:
- The arithmetic value of the remainder and the mapping of quotient bits onto C0, C1 and C3, including the OR into C3.
- The exact latency for each gap.
- The 63/64 gap boundary, the negative-gap and zero-divisor pass-through paths, and exact divisions that give a zero remainder.

// File: rtl/prem_pkg.sv
// Shared definitions for the partial remainder unit: controller states
// and the bit positions of the four condition-code bits.
package prem_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } prem_state_e;

    // Condition word layout {C3,C2,C1,C0}
    localparam int CC_C0 = 0;
    localparam int CC_C1 = 1;
    localparam int CC_C2 = 2;
    localparam int CC_C3 = 3;

endpackage

// File: rtl/prem_gap_ctl.sv
// Gap controller: derives the exponent gap, decides full versus partial
// reduction, and gives the loop iteration count and result exponent scale.
// Assumes PART_SHIFT < GAP_LIMIT and exponents that stay inside EXP_W bits.
module prem_gap_ctl #(
    parameter int EXP_W      = 12,
    parameter int GAP_LIMIT  = 64,
    parameter int PART_SHIFT = 42,
    parameter int CNT_W      = 7
) (
    input  logic signed [EXP_W-1:0] dvd_exp_i,
    input  logic signed [EXP_W-1:0] dvs_exp_i,
    output logic                    below_o,
    output logic                    partial_o,
    output logic [CNT_W-1:0]        iters_o,
    output logic signed [EXP_W-1:0] base_exp_o
);

    localparam logic signed [EXP_W:0] LIMIT_S = (EXP_W+1)'(GAP_LIMIT);

    logic signed [EXP_W:0] gap;
    logic [CNT_W-1:0]      eff_gap;

    // Classify the gap and pick the effective shift amount.
    always_comb begin
        gap        = {dvd_exp_i[EXP_W-1], dvd_exp_i} - {dvs_exp_i[EXP_W-1], dvs_exp_i};
        below_o    = gap[EXP_W];
        partial_o  = (gap >= LIMIT_S);
        eff_gap    = partial_o ? CNT_W'(PART_SHIFT) : gap[CNT_W-1:0];
        iters_o    = below_o ? '0 : eff_gap + CNT_W'(1);
        base_exp_o = partial_o ? (dvd_exp_i - EXP_W'(PART_SHIFT)) : dvs_exp_i;
    end

endmodule

// File: rtl/prem_divloop.sv
// Restoring shift-subtract loop: one quotient bit per clock for the
// loaded number of iterations. It keeps the three lowest quotient bits
// and a running remainder that ends below the divisor.
// Assumes both significands are normalized (MSB set) when iterations > 0.
module prem_divloop #(
    parameter int MW    = 16,
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [MW-1:0]    dvd_sig_i,
    input  logic [MW-1:0]    dvs_sig_i,
    input  logic [CNT_W-1:0] iters_i,
    output logic [MW-1:0]    rem_o,
    output logic [2:0]       qlow_o,
    output logic             idle_o
);

    logic [MW:0]      part_r;
    logic [MW-1:0]    dvs_r;
    logic [CNT_W-1:0] cnt_r;
    logic [2:0]       q_r;
    logic             fits;
    logic [MW:0]      trial;

    // Trial subtraction of the divisor from the partial remainder.
    always_comb begin
        fits  = (part_r >= {1'b0, dvs_r});
        trial = fits ? (part_r - {1'b0, dvs_r}) : part_r;
    end

    // Load the operands, then step one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_r <= '0;
            dvs_r  <= '0;
            cnt_r  <= '0;
            q_r    <= '0;
        end else if (load_i) begin
            part_r <= {1'b0, dvd_sig_i};
            dvs_r  <= dvs_sig_i;
            cnt_r  <= iters_i;
            q_r    <= '0;
        end else if (cnt_r != '0) begin
            q_r    <= {q_r[1:0], fits};
            part_r <= (cnt_r == CNT_W'(1)) ? trial : {trial[MW-1:0], 1'b0};
            cnt_r  <= cnt_r - CNT_W'(1);
        end
    end

    assign rem_o  = part_r[MW-1:0];
    assign qlow_o = q_r;
    assign idle_o = (cnt_r == '0);

    // After the final step the remainder is below the divisor.
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_r == CNT_W'(1)) |=> (part_r < {1'b0, dvs_r}));

endmodule

// File: rtl/prem_renorm.sv
// Renormalizer: shifts a remainder significand left by its leading-zero
// count and lowers the exponent to match. A zero input gives
// significand 0 and exponent 0. Purely combinational.
module prem_renorm #(
    parameter int MW    = 16,
    parameter int EXP_W = 12
) (
    input  logic [MW-1:0]           sig_i,
    input  logic signed [EXP_W-1:0] base_exp_i,
    output logic [MW-1:0]           sig_o,
    output logic signed [EXP_W-1:0] exp_o
);

    localparam int LZ_W = $clog2(MW + 1);

    logic [LZ_W-1:0] lz;

    // Count leading zeros; the highest set bit wins.
    always_comb begin
        lz = LZ_W'(MW);
        for (int i = 0; i < MW; i++) begin
            if (sig_i[i]) lz = LZ_W'(MW - 1 - i);
        end
    end

    // Apply the shift and exponent adjustment.
    always_comb begin
        sig_o = sig_i << lz;
        exp_o = (sig_i == '0) ? '0 : (base_exp_i - EXP_W'(lz));
    end

endmodule

// File: rtl/prem_unit.sv
// Top of the iterative partial remainder unit. It accepts a start pulse
// when idle, latches the operands, runs the quotient loop, and presents
// the renormalized remainder and the condition word with a one-cycle
// done pulse. Assumes normalized significands except for a zero divisor.
module prem_unit #(
    parameter int MW         = 16,
    parameter int EXP_W      = 12,
    parameter int GAP_LIMIT  = 64,
    parameter int PART_SHIFT = 42
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    dvd_sign_i,
    input  logic signed [EXP_W-1:0] dvd_exp_i,
    input  logic [MW-1:0]           dvd_sig_i,
    input  logic signed [EXP_W-1:0] dvs_exp_i,
    input  logic [MW-1:0]           dvs_sig_i,
    input  logic [3:0]              cc_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    rem_sign_o,
    output logic signed [EXP_W-1:0] rem_exp_o,
    output logic [MW-1:0]           rem_sig_o,
    output logic [3:0]              cc_o,
    output logic                    incomplete_o,
    output logic                    div_zero_o
);
    import prem_pkg::*;

    localparam int CNT_W = $clog2(GAP_LIMIT + 1);

    prem_state_e             state_r;
    logic                    accept;
    logic                    zero_dvs;
    logic                    below;
    logic                    partial;
    logic [CNT_W-1:0]        iters_g;
    logic [CNT_W-1:0]        iters_ld;
    logic signed [EXP_W-1:0] base_exp;

    logic                    sign_q;
    logic signed [EXP_W-1:0] exp_q;
    logic [MW-1:0]           sig_q;
    logic signed [EXP_W-1:0] base_q;
    logic [3:0]              cc_q;
    logic                    pass_q;
    logic                    err_q;
    logic                    partial_q;

    logic [MW-1:0]           loop_rem;
    logic [2:0]              qlow;
    logic                    loop_idle;
    logic [MW-1:0]           norm_sig;
    logic signed [EXP_W-1:0] norm_exp;
    logic [3:0]              cc_next;

    assign accept   = start_i && (state_r == ST_IDLE);
    assign zero_dvs = (dvs_sig_i == '0);
    assign iters_ld = zero_dvs ? '0 : iters_g;

    prem_gap_ctl #(
        .EXP_W(EXP_W), .GAP_LIMIT(GAP_LIMIT),
        .PART_SHIFT(PART_SHIFT), .CNT_W(CNT_W)
    ) u_gap (
        .dvd_exp_i (dvd_exp_i),
        .dvs_exp_i (dvs_exp_i),
        .below_o   (below),
        .partial_o (partial),
        .iters_o   (iters_g),
        .base_exp_o(base_exp)
    );

    prem_divloop #(.MW(MW), .CNT_W(CNT_W)) u_loop (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .dvd_sig_i(dvd_sig_i),
        .dvs_sig_i(dvs_sig_i),
        .iters_i  (iters_ld),
        .rem_o    (loop_rem),
        .qlow_o   (qlow),
        .idle_o   (loop_idle)
    );

    prem_renorm #(.MW(MW), .EXP_W(EXP_W)) u_norm (
        .sig_i     (loop_rem),
        .base_exp_i(base_q),
        .sig_o     (norm_sig),
        .exp_o     (norm_exp)
    );

    // Condition word for the finishing operation.
    always_comb begin
        cc_next = cc_q;
        if (err_q) begin
            cc_next = cc_q;
        end else if (pass_q) begin
            cc_next = {cc_q[CC_C3], 3'b000};
        end else if (partial_q) begin
            cc_next[CC_C2] = 1'b1;
        end else begin
            cc_next[CC_C0] = qlow[2];
            cc_next[CC_C1] = qlow[0];
            cc_next[CC_C2] = 1'b0;
            cc_next[CC_C3] = cc_q[CC_C3] | qlow[1];
        end
    end

    // Latch the operands and classification when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q    <= 1'b0;
            exp_q     <= '0;
            sig_q     <= '0;
            base_q    <= '0;
            cc_q      <= '0;
            pass_q    <= 1'b0;
            err_q     <= 1'b0;
            partial_q <= 1'b0;
        end else if (accept) begin
            sign_q    <= dvd_sign_i;
            exp_q     <= dvd_exp_i;
            sig_q     <= dvd_sig_i;
            base_q    <= base_exp;
            cc_q      <= cc_i;
            pass_q    <= zero_dvs || below;
            err_q     <= zero_dvs;
            partial_q <= partial && !zero_dvs;
        end
    end

    // Sequence idle/run and publish the result with a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_r      <= ST_IDLE;
            done_o       <= 1'b0;
            rem_sign_o   <= 1'b0;
            rem_exp_o    <= '0;
            rem_sig_o    <= '0;
            cc_o         <= '0;
            incomplete_o <= 1'b0;
            div_zero_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_r == ST_IDLE) begin
                if (accept) state_r <= ST_RUN;
            end else if (loop_idle) begin
                state_r      <= ST_IDLE;
                done_o       <= 1'b1;
                rem_sign_o   <= sign_q;
                rem_exp_o    <= pass_q ? exp_q : norm_exp;
                rem_sig_o    <= pass_q ? sig_q : norm_sig;
                cc_o         <= cc_next;
                incomplete_o <= partial_q;
                div_zero_o   <= err_q;
            end
        end
    end

    assign busy_o = (state_r == ST_RUN);

    // done lasts exactly one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // busy and done never overlap.
    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // Latched operands hold while running; a second start has no effect.
    assert_hold_operands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(sig_q) && $stable(exp_q) && $stable(cc_q)));

    // A published nonzero remainder is normalized.
    assert_msb_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !div_zero_o && rem_sig_o != '0) |-> rem_sig_o[MW-1]);

    // An incomplete result always carries C2.
    assert_partial_c2_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && incomplete_o) |-> cc_o[CC_C2]);

    // A zero-divisor result is never marked incomplete.
    assert_err_not_partial_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> !incomplete_o);

    // The result sign follows the dividend.
    assert_sign_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_sign_o == sign_q));

endmodule

// File: tb/sim_prem_unit.sv
module sim_prem_unit;

    localparam int CLK_PERIOD = 10;
    localparam int MW         = 16;
    localparam int EXP_W      = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_i = 1'b0;
    logic                    dvd_sign_i = 1'b0;
    logic signed [EXP_W-1:0] dvd_exp_i = '0;
    logic [MW-1:0]           dvd_sig_i = '0;
    logic signed [EXP_W-1:0] dvs_exp_i = '0;
    logic [MW-1:0]           dvs_sig_i = '0;
    logic [3:0]              cc_i = '0;
    logic                    busy_o, done_o, rem_sign_o, incomplete_o, div_zero_o;
    logic signed [EXP_W-1:0] rem_exp_o;
    logic [MW-1:0]           rem_sig_o;
    logic [3:0]              cc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit hung   = 1'b0;

    // Expected results
    bit          e_sign, e_inc, e_err;
    int          e_exp, e_lat;
    logic [MW-1:0] e_sig;
    logic [3:0]  e_cc;

    prem_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dvd_sign_i(dvd_sign_i), .dvd_exp_i(dvd_exp_i), .dvd_sig_i(dvd_sig_i),
        .dvs_exp_i(dvs_exp_i), .dvs_sig_i(dvs_sig_i), .cc_i(cc_i),
        .busy_o(busy_o), .done_o(done_o), .rem_sign_o(rem_sign_o),
        .rem_exp_o(rem_exp_o), .rem_sig_o(rem_sig_o), .cc_o(cc_o),
        .incomplete_o(incomplete_o), .div_zero_o(div_zero_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) hung <= 1'b1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model from the requirements.
    task automatic model(input bit s, input int ae, input logic [MW-1:0] a,
                         input int be, input logic [MW-1:0] b, input logic [3:0] ci);
        int d, g, base, lz;
        logic [127:0] num, q, rem;
        d = ae - be;
        e_sign = s; e_err = 0; e_inc = 0;
        if (b == 0) begin
            e_err = 1; e_sig = a; e_exp = ae; e_cc = ci; e_lat = 1;
        end else if (d < 0) begin
            e_sig = a; e_exp = ae; e_cc = {ci[3], 3'b000}; e_lat = 1;
        end else begin
            e_inc = (d >= 64);
            g     = e_inc ? 42 : d;
            base  = e_inc ? ae - 42 : be;
            num   = {112'd0, a} << g;
            q     = num / {112'd0, b};
            rem   = num % {112'd0, b};
            e_lat = g + 2;
            if (rem == 0) begin
                e_sig = '0; e_exp = 0;
            end else begin
                lz = 0;
                while (rem[MW-1-lz] == 1'b0) lz++;
                e_sig = MW'(rem << lz);
                e_exp = base - lz;
            end
            if (e_inc) e_cc = {ci[3], 1'b1, ci[1:0]};
            else       e_cc = {ci[3] | q[1], 1'b0, q[0], q[2]};
        end
    endtask

    // Run one operation; optionally fire a stray start while busy.
    task automatic run_op(input bit s, input int ae, input logic [MW-1:0] a,
                          input int be, input logic [MW-1:0] b,
                          input logic [3:0] ci, input bit stray);
        int k;
        bit saw_busy_gap;
        model(s, ae, a, be, b, ci);
        @(negedge clk);
        dvd_sign_i = s; dvd_exp_i = EXP_W'(ae); dvd_sig_i = a;
        dvs_exp_i = EXP_W'(be); dvs_sig_i = b; cc_i = ci; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        k = 0;
        saw_busy_gap = 0;
        while (!done_o && k < 200 && !hung) begin
            if (!busy_o) saw_busy_gap = 1;
            if (stray && k == 1) begin
                start_i = 1'b1; dvd_sign_i = ~s; dvd_sig_i = 16'hC001;
                dvd_exp_i = EXP_W'(ae + 3); dvs_sig_i = 16'h8001; cc_i = ~ci;
            end else begin
                start_i = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        start_i = 1'b0;
        check(done_o, "R8 done seen", done_o, 1);
        check(k == e_lat, "R8 latency", k, e_lat);
        check(!saw_busy_gap && !busy_o, "R11 busy window", busy_o, 0);
        check(rem_sign_o == e_sign, "R5 sign", rem_sign_o, e_sign);
        check(rem_sig_o == e_sig, stray ? "R9 sig" : "R1 sig", rem_sig_o, e_sig);
        check(int'(rem_exp_o) == e_exp, "R6 exp", rem_exp_o, e_exp);
        check(cc_o == e_cc, e_inc ? "R4 cc" : "R3 cc", cc_o, e_cc);
        check(incomplete_o == e_inc, "R2 incomplete", incomplete_o, e_inc);
        check(div_zero_o == e_err, "R10 err", div_zero_o, e_err);
        @(negedge clk);
        check(!done_o, "R8 pulse", done_o, 0);
    endtask

    initial begin
        int seed;
        seed = 13;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // Reset state
        check(!busy_o && !done_o && rem_sig_o == 0 && cc_o == 0, "R11 reset", busy_o, 0);

        // R1 R3: gap 0, quotient 1 and quotient 0
        run_op(0, 5, 16'hC000, 5, 16'h8000, 4'b0000, 0);
        run_op(1, 5, 16'h8000, 5, 16'hC000, 4'b0000, 0);
        // R7: negative gap passes dividend
        run_op(1, 3, 16'hA5A5, 4, 16'h8001, 4'b1111, 0);
        // R10: zero divisor
        run_op(0, 7, 16'h9234, 2, 16'h0000, 4'b0110, 0);
        // R5: exact division, zero remainder keeps sign
        run_op(1, 10, 16'hC000, 8, 16'hC000, 4'b0000, 0);
        // R3: C3 OR with prior bit
        run_op(0, 2, 16'h8000, 0, 16'hFFFF, 4'b1000, 0);
        // R1/R2 boundary: gap 63 complete, gap 64 partial
        run_op(0, 63, 16'hF00D, 0, 16'h8003, 4'b0000, 0);
        run_op(0, 64, 16'hF00D, 0, 16'h8003, 4'b1011, 0);
        // R9: stray start while busy
        run_op(0, 20, 16'hB7E1, 1, 16'h9001, 4'b0000, 1);

        for (int n = 0; n < 150 && !hung; n++) begin
            int be, d;
            logic [MW-1:0] a, b;
            be = int'($urandom_range(400)) - 200;
            d  = int'($urandom_range(106)) - 6;
            a  = MW'($urandom) | 16'h8000;
            b  = MW'($urandom) | 16'h8000;
            run_op(1'($urandom), be + d, a, be, b, 4'($urandom), (n % 17) == 5);
        end

        if (hung) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule